// File: doc/BRIEF.md
# Signed Decade Result Counter with Display Latch and Range Flags

This block holds the reading of an integrating converter. It keeps a signed value as a sign bit and six binary-coded-decimal decades. On each enabled clock it adds or subtracts one unit at a chosen decade weight (1, 10, 100, and so on). The successive correction passes of a conversion can therefore refine one running result, and an offset reading can be taken away from it. When a subtraction passes through zero, the sign flips and the count carries on in the magnitude. The value never wraps.

A display register and two range flags sit after the counter. A strobe from the sequencer marks the end of a conversion. A two-bit mode input selects one of three behaviours. In free-run mode the display loads at each strobe fall. In hold mode the shown reading is frozen. In transparent mode the display follows the live count. The flags report a magnitude too large for the display (above 19,999) or too small for good resolution (below 1000). They are meant to drive range switching outside the block.

Top module: `dec_result_counter`

## Requirements
- R1: After synchronous reset the counter, the shown digits, the shown sign, the overrange flag and the underrange flag are all zero.
- R2: With `cnt_en` high and `cnt_dn` low, a non-negative value grows by 10^`weight_sel` in the next clock. A decimal carry ripples through all higher decades in that same clock (9999 + 1 = 10000). Decade i is bits [4i+3:4i] of every digit bus.
- R3: With `cnt_dn` high and a positive value of at least 10^`weight_sel`, the value shrinks by that weight in one clock. Borrows ripple through the decades (10000 - 1 = 9999).
- R4: When a step moves the value toward zero by more than its magnitude, the result takes the other sign with magnitude weight - |value|. A zero result is always shown with sign 0 (positive). Sign 1 means negative.
- R5: The magnitude saturates at 999999 and keeps its sign. It never wraps.
- R6: `clr` zeroes the counter in the next clock and takes priority over counting. The display is not touched by `clr`.
- R7: A strobe fall is a clock edge at which `latch_stb` is sampled low after being sampled high at the previous edge. In free-run mode (`lh_mode` = 00), such an edge loads the digits, the sign and both flags from the counter value held just before that edge.
- R8: The overrange flag is set by a latch when the latched magnitude is greater than 19999.
- R9: The underrange flag is set by a latch when the latched magnitude is less than 1000.
- R10: Both flags change only at a strobe fall. Between strobe falls they hold, whatever the counter does.
- R11: In hold mode (`lh_mode` = 01, and also the unused code 11), the digits, sign and flags do not change, strobe falls included.
- R12: In transparent mode (`lh_mode` = 10), the digits and sign show the counter value one clock later. The flags still update only at strobe falls.
- R13: A `weight_sel` of 6 or 7 with `cnt_en` high leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero the counter |
| cnt_en | input | 1 | Take one step this clock |
| cnt_dn | input | 1 | Step direction: 0 adds, 1 subtracts |
| weight_sel | input | 3 | Decade weight exponent of the step |
| latch_stb | input | 1 | End-of-conversion strobe; its fall latches |
| lh_mode | input | 2 | 00 free run, 01 hold, 10 transparent, 11 as hold |
| disp_digits | output | 24 | Shown magnitude, six BCD decades |
| disp_neg | output | 1 | Shown sign, 1 = negative |
| over_flag | output | 1 | Latched magnitude above 19999 |
| under_flag | output | 1 | Latched magnitude below 1000 |

## Verification
Each output has its own latency. A count or clear enabled in one cycle changes the counter at the next edge. In transparent mode that value appears at the display one edge later. A strobe fall captures the counter as it stood before the edge, so the latched digits and flags are valid right after that same edge. The bench steps a model of the counter, the display and the flags at each rising edge, using the inputs that were sampled there. It queues the expected outputs just after the edge, and a monitor compares them a little later in the same cycle. Every compare therefore sits between the edge that produces a result and the next edge that could change it.

// File: rtl/drc_pkg.sv
package drc_pkg;

    parameter int DEC_N = 6;
    localparam int DIG_W = 4;
    localparam int MAG_W = DEC_N * DIG_W;
    localparam int SEL_W = $clog2(DEC_N);
    // overrange: magnitude reaches OVR_LEAD * 10^OVR_DEC
    localparam int OVR_DEC  = DEC_N - 2;
    localparam int OVR_LEAD = 2;
    // underrange: no digit at or above decade UND_DEC
    localparam int UND_DEC  = DEC_N - 3;

    typedef logic [DIG_W-1:0] bcd_t;
    typedef logic [DEC_N-1:0][DIG_W-1:0] mag_t;

    typedef struct packed {
        logic neg;
        mag_t mag;
    } reading_t;

    typedef enum logic [1:0] {
        LM_FREE   = 2'b00,
        LM_HOLD   = 2'b01,
        LM_TRANSP = 2'b10,
        LM_SPARE  = 2'b11
    } lh_mode_e;

    function automatic logic mag_zero(input mag_t m);
        return (m == '0);
    endfunction

    // all decades at or above position pos are zero (magnitude < 10^pos)
    function automatic logic mag_below(input mag_t m, input int pos);
        logic r;
        r = 1'b1;
        for (int i = 0; i < DEC_N; i++)
            if (i >= pos && m[i] != '0) r = 1'b0;
        return r;
    endfunction

    function automatic logic mag_over(input mag_t m);
        logic r;
        r = (m[OVR_DEC] >= bcd_t'(OVR_LEAD));
        for (int i = OVR_DEC + 1; i < DEC_N; i++)
            if (m[i] != '0) r = 1'b1;
        return r;
    endfunction

    function automatic logic mag_is_bcd(input mag_t m);
        logic r;
        r = 1'b1;
        for (int i = 0; i < DEC_N; i++)
            if (m[i] > bcd_t'(9)) r = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/drc_decade.sv
module drc_decade
    import drc_pkg::*;
(
    input  bcd_t d,
    input  logic ci,
    input  logic sub,
    output bcd_t q,
    output logic co
);
    always_comb begin
        q  = d;
        co = 1'b0;
        if (ci) begin
            if (sub) begin
                if (d == bcd_t'(0)) begin
                    q  = bcd_t'(9);
                    co = 1'b1;
                end else begin
                    q = d - bcd_t'(1);
                end
            end else begin
                if (d == bcd_t'(9)) begin
                    q  = bcd_t'(0);
                    co = 1'b1;
                end else begin
                    q = d + bcd_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/drc_step_unit.sv
module drc_step_unit
    import drc_pkg::*;
(
    input  reading_t         cur,
    input  logic             dn,
    input  logic [SEL_W-1:0] sel,
    output reading_t         res
);
    logic grow, below, flip, sub_mode;
    logic [SEL_W-1:0] inj;
    mag_t opnd, sum;
    logic [DEC_N-1:0] cin, cout;

    always_comb begin
        grow     = (dn == cur.neg);
        below    = mag_below(cur.mag, int'(sel));
        flip     = !grow && below;
        sub_mode = !grow && !below;
        inj      = flip ? '0 : sel;
        for (int i = 0; i < DEC_N; i++) begin
            if (!flip)
                opnd[i] = cur.mag[i];
            else if (SEL_W'(i) < sel)
                opnd[i] = bcd_t'(9) - cur.mag[i];
            else
                opnd[i] = '0;
        end
    end

    for (genvar g = 0; g < DEC_N; g++) begin : g_dec
        if (g == 0) begin : g_lsd
            assign cin[g] = (inj == SEL_W'(g));
        end else begin : g_upper
            assign cin[g] = (inj == SEL_W'(g)) | cout[g-1];
        end
        drc_decade u_dec (
            .d   (opnd[g]),
            .ci  (cin[g]),
            .sub (sub_mode),
            .q   (sum[g]),
            .co  (cout[g])
        );
    end

    always_comb begin
        if (grow && cout[DEC_N-1])
            res.mag = mag_t'({DEC_N{bcd_t'(9)}});
        else
            res.mag = sum;
        res.neg = flip ? !cur.neg : cur.neg;
        if (mag_zero(res.mag)) res.neg = 1'b0;
    end
endmodule

// File: rtl/drc_range_flags.sv
module drc_range_flags
    import drc_pkg::*;
(
    input  mag_t mag,
    output logic ovr,
    output logic und
);
    always_comb begin
        ovr = mag_over(mag);
        und = mag_below(mag, UND_DEC);
    end
endmodule

// File: rtl/drc_disp_latch.sv
module drc_disp_latch
    import drc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lh_mode_e mode,
    input  logic     stb_fall,
    input  reading_t live,
    output reading_t shown,
    output logic     ovr,
    output logic     und
);
    logic live_ovr, live_und;

    drc_range_flags u_flags (
        .mag (live.mag),
        .ovr (live_ovr),
        .und (live_und)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shown <= '0;
            ovr   <= 1'b0;
            und   <= 1'b0;
        end else begin
            case (mode)
                LM_FREE: begin
                    if (stb_fall) begin
                        shown <= live;
                        ovr   <= live_ovr;
                        und   <= live_und;
                    end
                end
                LM_TRANSP: begin
                    shown <= live;
                    if (stb_fall) begin
                        ovr <= live_ovr;
                        und <= live_und;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dec_result_counter.sv
module dec_result_counter
    import drc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic             cnt_dn,
    input  logic [SEL_W-1:0] weight_sel,
    input  logic             latch_stb,
    input  logic [1:0]       lh_mode,
    output logic [MAG_W-1:0] disp_digits,
    output logic             disp_neg,
    output logic             over_flag,
    output logic             under_flag
);
    reading_t cnt_q, cnt_step, shown;
    logic     stb_q, stb_fall, sel_ok;

    assign stb_fall = stb_q & ~latch_stb;
    assign sel_ok   = int'(weight_sel) < DEC_N;

    drc_step_unit u_step (
        .cur (cnt_q),
        .dn  (cnt_dn),
        .sel (weight_sel),
        .res (cnt_step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= latch_stb;
            if (clr)
                cnt_q <= '0;
            else if (cnt_en && sel_ok)
                cnt_q <= cnt_step;
        end
    end

    drc_disp_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .mode     (lh_mode_e'(lh_mode)),
        .stb_fall (stb_fall),
        .live     (cnt_q),
        .shown    (shown),
        .ovr      (over_flag),
        .und      (under_flag)
    );

    assign disp_digits = shown.mag;
    assign disp_neg    = shown.neg;
endmodule

// File: rtl/drc_checker.sv
module drc_checker
    import drc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             cnt_en,
    input logic [SEL_W-1:0] weight_sel,
    input logic [1:0]       lh_mode,
    input logic             stb_fall,
    input reading_t         live,
    input logic [MAG_W-1:0] disp_digits,
    input logic             disp_neg,
    input logic             over_flag,
    input logic             under_flag
);
    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        mag_is_bcd(live.mag));

    // R4
    zero_positive_chk: assert property (@(posedge clk) disable iff (rst)
        mag_zero(live.mag) |-> !live.neg);

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (mag_zero(live.mag) && !live.neg));

    // R13
    bad_weight_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !clr && int'(weight_sel) >= DEC_N) |=> ($stable(live.mag) && $stable(live.neg)));

    // R10
    flag_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(over_flag) || !$stable(under_flag)) |-> $past(stb_fall));

    // R11
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (lh_mode[0]) |=> ($stable(disp_digits) && $stable(disp_neg) && $stable(over_flag) && $stable(under_flag)));

    // R12
    transp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (lh_mode == 2'b10) |=> (disp_digits == $past(live.mag) && disp_neg == $past(live.neg)));
endmodule

bind dec_result_counter drc_checker u_drc_chk (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .cnt_en      (cnt_en),
    .weight_sel  (weight_sel),
    .lh_mode     (lh_mode),
    .stb_fall    (stb_fall),
    .live        (cnt_q),
    .disp_digits (disp_digits),
    .disp_neg    (disp_neg),
    .over_flag   (over_flag),
    .under_flag  (under_flag)
);

// File: tb/dec_result_counter_bench.sv
module dec_result_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_MAG    = 999999;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0, cnt_en = 1'b0, cnt_dn = 1'b0, latch_stb = 1'b0;
    logic [2:0]  weight_sel = '0;
    logic [1:0]  lh_mode = 2'b00;
    logic [23:0] disp_digits;
    logic        disp_neg, over_flag, under_flag;

    dec_result_counter u_dec_result_counter (
        .clk(clk), .rst(rst), .clr(clr), .cnt_en(cnt_en), .cnt_dn(cnt_dn),
        .weight_sel(weight_sel), .latch_stb(latch_stb), .lh_mode(lh_mode),
        .disp_digits(disp_digits), .disp_neg(disp_neg),
        .over_flag(over_flag), .under_flag(under_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    val;
        bit    ov;
        bit    un;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_checks = 0, n_errors = 0;
    string cur_tag = "R1";
    bit    finished = 1'b0;

    // reference state
    int m_cnt = 0, m_disp = 0;
    bit m_ov = 0, m_un = 0, m_stbp = 0;

    function automatic int pow10(input int k);
        int r = 1;
        for (int i = 0; i < k; i++) r = r * 10;
        return r;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic logic [23:0] to_bcd(input int mag);
        logic [23:0] r;
        int m = mag;
        for (int i = 0; i < 6; i++) begin
            r[4*i +: 4] = 4'(m % 10);
            m = m / 10;
        end
        return r;
    endfunction

    task automatic step(input bit en, input bit dn, input int k, input bit cl,
                        input bit stb, input logic [1:0] md);
        bit   fall;
        exp_t e;
        @(negedge clk);
        cnt_en = en; cnt_dn = dn; weight_sel = 3'(k); clr = cl;
        latch_stb = stb; lh_mode = md;
        @(posedge clk);
        fall = m_stbp && !stb;
        if (md == 2'b00 && fall) begin
            m_disp = m_cnt;
            m_ov = iabs(m_cnt) > 19999; m_un = iabs(m_cnt) < 1000;
        end else if (md == 2'b10) begin
            m_disp = m_cnt;
            if (fall) begin
                m_ov = iabs(m_cnt) > 19999; m_un = iabs(m_cnt) < 1000;
            end
        end
        if (cl) m_cnt = 0;
        else if (en && k < 6) begin
            m_cnt = dn ? m_cnt - pow10(k) : m_cnt + pow10(k);
            if (m_cnt > MAX_MAG) m_cnt = MAX_MAG;
            if (m_cnt < -MAX_MAG) m_cnt = -MAX_MAG;
        end
        m_stbp = stb;
        #1;
        e.val = m_disp; e.ov = m_ov; e.un = m_un; e.tag = cur_tag;
        sb_q.push_back(e);
    endtask

    // monitor: compares shortly after each edge, before the next
    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (disp_digits !== to_bcd(iabs(e.val)) || disp_neg !== (e.val < 0) ||
                over_flag !== e.ov || under_flag !== e.un) begin
                n_errors++;
                $display("FAIL %s: got digits=%h neg=%b ov=%b un=%b, expected digits=%h neg=%b ov=%b un=%b",
                         e.tag, disp_digits, disp_neg, over_flag, under_flag,
                         to_bcd(iabs(e.val)), e.val < 0, e.ov, e.un);
            end
        end
    end

    task automatic set_value(input int v, input logic [1:0] md);
        int mag = iabs(v);
        step(0, 0, 0, 1, 0, md);
        for (int k = 5; k >= 0; k--) begin
            int dg = (mag / pow10(k)) % 10;
            for (int j = 0; j < dg; j++) step(1, v < 0, k, 0, 0, md);
        end
    endtask

    task automatic latch_pulse(input logic [1:0] md);
        step(0, 0, 0, 0, 1, md);
        step(0, 0, 0, 0, 0, md);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: got no end, expected end of run");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        cur_tag = "R1";
        step(0, 0, 0, 0, 0, 2'b00);
        step(0, 0, 0, 0, 0, 2'b00);

        // R2 ripple carry, shown through the transparent path (R12)
        cur_tag = "R2";
        for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, 2'b10);
        set_value(9999, 2'b10);
        step(1, 0, 0, 0, 0, 2'b10);            // 10000
        step(0, 0, 0, 0, 0, 2'b10);
        set_value(999, 2'b10);
        step(1, 0, 1, 0, 0, 2'b10);            // 1009
        step(0, 0, 0, 0, 0, 2'b10);

        // R3 borrow ripple
        cur_tag = "R3";
        set_value(10000, 2'b10);
        step(1, 1, 0, 0, 0, 2'b10);            // 9999
        step(1, 1, 1, 0, 0, 2'b10);            // 9989
        step(0, 0, 0, 0, 0, 2'b10);

        // R4 zero crossing both ways
        cur_tag = "R4";
        step(0, 0, 0, 1, 0, 2'b10);
        step(1, 1, 2, 0, 0, 2'b10);            // -100
        step(1, 0, 3, 0, 0, 2'b10);            // 900
        step(1, 1, 3, 0, 0, 2'b10);            // -100
        step(1, 0, 2, 0, 0, 2'b10);            // 0, positive
        step(1, 1, 0, 0, 0, 2'b10);            // -1
        step(1, 0, 1, 0, 0, 2'b10);            // 9
        step(0, 0, 0, 0, 0, 2'b10);

        // R5 saturation
        cur_tag = "R5";
        set_value(999999, 2'b10);
        step(1, 0, 0, 0, 0, 2'b10);
        step(1, 0, 5, 0, 0, 2'b10);
        set_value(-999990, 2'b10);
        step(1, 1, 2, 0, 0, 2'b10);
        step(0, 0, 0, 0, 0, 2'b10);

        // R6 clear beats count
        cur_tag = "R6";
        step(1, 1, 4, 1, 0, 2'b10);
        step(0, 0, 0, 0, 0, 2'b10);

        // R13 out-of-range weight
        cur_tag = "R13";
        step(1, 0, 2, 0, 0, 2'b10);
        step(1, 0, 6, 0, 0, 2'b10);
        step(1, 1, 7, 0, 0, 2'b10);
        step(0, 0, 0, 0, 0, 2'b10);

        // R7 R8 R9 free-run latching and thresholds
        cur_tag = "R8";
        set_value(25000, 2'b00); latch_pulse(2'b00);
        set_value(20000, 2'b00); latch_pulse(2'b00);
        set_value(-20000, 2'b00); latch_pulse(2'b00);
        set_value(19999, 2'b00); latch_pulse(2'b00);
        cur_tag = "R9";
        set_value(500, 2'b00); latch_pulse(2'b00);
        set_value(999, 2'b00); latch_pulse(2'b00);
        set_value(-1000, 2'b00); latch_pulse(2'b00);
        cur_tag = "R7";
        set_value(5000, 2'b00);
        step(0, 0, 0, 0, 1, 2'b00);
        step(1, 0, 3, 0, 0, 2'b00);            // latches 5000, not 6000
        step(0, 0, 0, 0, 0, 2'b00);

        // R10 flags and display hold between strobes
        cur_tag = "R10";
        set_value(300, 2'b00);
        step(0, 0, 0, 0, 1, 2'b00);
        step(0, 0, 0, 0, 1, 2'b00);

        // R11 hold modes
        cur_tag = "R11";
        latch_pulse(2'b01);
        set_value(-45000, 2'b01);
        latch_pulse(2'b01);
        latch_pulse(2'b11);
        step(1, 0, 0, 0, 0, 2'b11);

        // R12 transparent display, flags only at strobe fall
        cur_tag = "R12";
        step(1, 0, 0, 0, 0, 2'b10);
        step(1, 0, 0, 0, 0, 2'b10);
        latch_pulse(2'b10);
        step(1, 1, 5, 0, 0, 2'b10);
        step(0, 0, 0, 0, 0, 2'b10);

        @(posedge clk); @(posedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule